// File: doc/BRIEF.md
# Field-Policy Register Bank

This block is a small register bank that sits behind a single-cycle processor slave port with a select, a write flag, a word address, write data and read data. Each register is made of fields. Every field has a fixed bit position and width, an access class, a rule that turns a bus write into a new field value, and an optional side effect of a bus read. The stored field values go out to the surrounding logic on one flat vector. The read-only field takes its value from a hardware status input.

One further word holds interrupt flags. A hardware event sets a flag, and a bus read of that word clears it. The bank decodes a write strobe for each register, applies the field rules, and returns read data through an address mux. The field layout and the reset word of each register are constants in the package. The module parameters set the address width and the number of interrupt flags.

Top module: `fbank_top`

## Requirements
- R1: After reset the registers read back as follows. Word 0 is `{hw_stat, 4'h0, 4'h0, 4'h0, 4'hF, 8'h5A}`. Word 1 is `32'h000F0011`. Word 2 is `32'h00A50700`. Word 3 is `32'h0000000F`. Word 4 is `32'h0`. `fld_out` holds `{32'h0000000F, 32'h00A50733, 32'h000F2211, 32'h00000F5A}` (word 3 down to word 0).
- R2: A register changes on a write only when `bus_sel` is high, `bus_wr` is high and `bus_addr` equals that register's word address (0 to 3). With `bus_sel` low, no field changes.
- R3: For a read (`bus_sel` high, `bus_wr` low), `bus_rdata` returns the register whose address matches. Addresses above 4 read as zero, and writes to them change nothing.
- R4: Word 0 bits [31:24] form a read-only field that reflects `hw_stat`. Bus writes do not affect it, and it shows as zero on `fld_out`.
- R5: Word 2 bits [7:0] are write-only. A write stores the value and drives it onto `fld_out`, but a bus read of those bits returns zero.
- R6: Word 0 has three write rules: bits [11:8] clear where the write data has ones, bits [15:12] set where it has ones, and bits [19:16] toggle where it has ones. Bits [7:0] take the write data directly.
- R7: Word 1 has three write rules: bits [19:16] clear where the write data has zeros, bits [23:20] set where it has zeros, and bits [27:24] toggle where it has zeros.
- R8: Any write to word 2 clears bits [11:8] and sets bits [15:12] to all ones, whatever the write data.
- R9: Word 1 bits [7:0] (readable) and bits [15:8] (reading as zero) each accept only the first write after reset. Later writes leave them unchanged until the next reset.
- R10: A read returns the value before any read side effect. The effect then applies at the end of that cycle: word 2 bits [23:16] clear, word 2 bits [31:24] become all ones, and word 3 bits [7:0] invert.
- R11: Word 4 holds `irq_stat`. A high `hw_evt` bit sets the matching flag. A read of word 4 clears all flags. An event in the same cycle as that read leaves its flag set.
- R12: Bus writes to word 4 do not clear or set any interrupt flag.
- R13: Read data is valid in the same cycle as the request, with no wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Transaction targets this block |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| hw_stat | input | RO_BITS | Value of the read-only field(s) |
| hw_evt | input | IRQ_W | Interrupt event pulses |
| fld_out | output | 4*32 | Stored field values, word 0 in the low bits |
| irq_stat | output | IRQ_W | Interrupt flags |

## Verification
The hardest situations to reach from the ports are state-dependent. One is a once-only field that has already been written and is then written again. Another is an interrupt flag that is being read clear in the same cycle an event sets it. A third is a read with side effects, whose result depends on every earlier read of the same word.

Directed steps reach the collision and the second write explicitly. A mid-run reset shows that the once-only fields accept a new write afterwards. A long random phase then mixes reads, writes, idle cycles, unmapped addresses and events. Because of this mix, the side effects pile up in orders no directed list would cover.

// File: rtl/fbank_pkg.sv
// Shared types and the field layout of the register bank.
// Assumes: 32-bit registers, word addressing, one row per field.
package fbank_pkg;
    localparam int DATA_W     = 32;
    localparam int NUM_REGS   = 4;
    localparam int NUM_FIELDS = 16;
    localparam int IRQ_OFF    = NUM_REGS;   // interrupt word follows the field registers

    typedef enum logic [2:0] {ACC_RO, ACC_WO, ACC_RW, ACC_WONCE, ACC_RWONCE} acc_e;
    typedef enum logic [3:0] {
        WR_PLAIN, WR_ONE_CLR, WR_ONE_SET, WR_ONE_TOG,
        WR_ZERO_CLR, WR_ZERO_SET, WR_ZERO_TOG, WR_ANY_CLR, WR_ANY_SET
    } wrule_e;
    typedef enum logic [1:0] {RD_KEEP, RD_CLR, RD_SET, RD_INV} reff_e;

    typedef struct packed {
        logic [7:0] reg_idx;
        logic [7:0] lsb;
        logic [7:0] width;
        acc_e       acc;
        wrule_e     rule;
        reff_e      reff;
    } field_t;

    localparam field_t FIELDS [NUM_FIELDS] = '{
        '{8'd0,  8'd0, 8'd8, ACC_RW,     WR_PLAIN,    RD_KEEP},
        '{8'd0,  8'd8, 8'd4, ACC_RW,     WR_ONE_CLR,  RD_KEEP},
        '{8'd0, 8'd12, 8'd4, ACC_RW,     WR_ONE_SET,  RD_KEEP},
        '{8'd0, 8'd16, 8'd4, ACC_RW,     WR_ONE_TOG,  RD_KEEP},
        '{8'd0, 8'd24, 8'd8, ACC_RO,     WR_PLAIN,    RD_KEEP},
        '{8'd1,  8'd0, 8'd8, ACC_RWONCE, WR_PLAIN,    RD_KEEP},
        '{8'd1,  8'd8, 8'd8, ACC_WONCE,  WR_PLAIN,    RD_KEEP},
        '{8'd1, 8'd16, 8'd4, ACC_RW,     WR_ZERO_CLR, RD_KEEP},
        '{8'd1, 8'd20, 8'd4, ACC_RW,     WR_ZERO_SET, RD_KEEP},
        '{8'd1, 8'd24, 8'd4, ACC_RW,     WR_ZERO_TOG, RD_KEEP},
        '{8'd2,  8'd0, 8'd8, ACC_WO,     WR_PLAIN,    RD_KEEP},
        '{8'd2,  8'd8, 8'd4, ACC_RW,     WR_ANY_CLR,  RD_KEEP},
        '{8'd2, 8'd12, 8'd4, ACC_RW,     WR_ANY_SET,  RD_KEEP},
        '{8'd2, 8'd16, 8'd8, ACC_RW,     WR_PLAIN,    RD_CLR},
        '{8'd2, 8'd24, 8'd8, ACC_RW,     WR_PLAIN,    RD_SET},
        '{8'd3,  8'd0, 8'd8, ACC_RW,     WR_PLAIN,    RD_INV}
    };

    localparam logic [DATA_W-1:0] REG_RST [NUM_REGS] = '{
        32'h00000F5A, 32'h000F2211, 32'h00A50733, 32'h0000000F
    };

    // Bit position in hw_stat of read-only field idx (sum of earlier read-only widths)
    function automatic int ro_base(int idx);
        int s = 0;
        for (int k = 0; k < idx; k++)
            if (FIELDS[k].acc == ACC_RO) s += int'(FIELDS[k].width);
        return s;
    endfunction

    localparam int RO_BITS = ro_base(NUM_FIELDS);
endpackage

// File: rtl/fbank_field.sv
// One stored field: applies its write rule, once-only gating and read side effect.
// Assumes: read-only fields are not built with this module; write and read
// strobes are never high together (one bus transaction per cycle).
module fbank_field import fbank_pkg::*; #(
    parameter int         W    = 8,
    parameter acc_e       ACC  = ACC_RW,
    parameter wrule_e     RULE = WR_PLAIN,
    parameter reff_e      REFF = RD_KEEP,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_stb,
    input  logic         rd_stb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] fld_q,
    output logic [W-1:0] rd_val
);
    localparam bit READABLE = (ACC == ACC_RW) || (ACC == ACC_RWONCE);
    localparam bit ONCE     = (ACC == ACC_WONCE) || (ACC == ACC_RWONCE);

    logic [W-1:0] q, q_wr;
    logic         taken;

    // Value the field would take from the current write data
    always_comb begin
        case (RULE)
            WR_ONE_CLR:  q_wr = q & ~wdata;
            WR_ONE_SET:  q_wr = q | wdata;
            WR_ONE_TOG:  q_wr = q ^ wdata;
            WR_ZERO_CLR: q_wr = q & wdata;
            WR_ZERO_SET: q_wr = q | ~wdata;
            WR_ZERO_TOG: q_wr = q ^ ~wdata;
            WR_ANY_CLR:  q_wr = '0;
            WR_ANY_SET:  q_wr = '1;
            default:     q_wr = wdata;
        endcase
    end

    // Field storage: write with once-gating, else read side effect
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= RST;
            taken <= 1'b0;
        end else if (wr_stb && !(ONCE && taken)) begin
            q     <= q_wr;
            taken <= 1'b1;
        end else if (rd_stb && READABLE) begin
            case (REFF)
                RD_CLR:  q <= '0;
                RD_SET:  q <= '1;
                RD_INV:  q <= ~q;
                default: q <= q;
            endcase
        end
    end

    assign fld_q  = q;
    assign rd_val = READABLE ? q : '0;
endmodule

// File: rtl/fbank_irq.sv
// Interrupt flag word: events set flags, a read of the word clears them, set wins.
// Assumes: rd_clr is a single-cycle strobe from the address decoder.
module fbank_irq #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         rd_clr,
    output logic [W-1:0] stat
);
    // Flag update: clear on read first, then OR in new events
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (stat & ~{W{rd_clr}}) | evt;
    end
endmodule

// File: rtl/fbank_decode.sv
// Address decode and read mux. Strobes per register; read data picked by
// comparing the address against each word address in order.
// Assumes: register r lives at word address r; entry NREG is the interrupt word.
module fbank_decode import fbank_pkg::*; #(
    parameter int ADDR_W = 4,
    parameter int NREG   = 4
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] reg_rd [NREG+1],
    output logic [NREG-1:0]   wr_stb,
    output logic [NREG:0]     rd_stb,
    output logic [DATA_W-1:0] bus_rdata
);
    // Per-register write and read strobes
    always_comb begin
        for (int r = 0; r < NREG; r++)
            wr_stb[r] = bus_sel && bus_wr && (bus_addr == ADDR_W'(r));
        for (int r = 0; r <= NREG; r++)
            rd_stb[r] = bus_sel && !bus_wr && (bus_addr == ADDR_W'(r));
    end

    // Read mux: first matching word wins, no match reads zero
    always_comb begin
        logic found;
        found     = 1'b0;
        bus_rdata = '0;
        for (int r = 0; r <= NREG; r++) begin
            if (!found && bus_sel && !bus_wr && bus_addr == ADDR_W'(r)) begin
                bus_rdata = reg_rd[r];
                found     = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fbank_top.sv
// Register bank top: builds one cell per field from the package layout,
// assembles register words, and joins decode and interrupt word.
// Assumes: IRQ_W <= 32, ADDR_W wide enough to reach the interrupt word.
module fbank_top import fbank_pkg::*; #(
    parameter int ADDR_W = 4,
    parameter int IRQ_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [RO_BITS-1:0]         hw_stat,
    input  logic [IRQ_W-1:0]           hw_evt,
    output logic [NUM_REGS*DATA_W-1:0] fld_out,
    output logic [IRQ_W-1:0]           irq_stat
);
    logic [NUM_REGS-1:0] wr_stb;
    logic [NUM_REGS:0]   rd_stb;
    logic [DATA_W-1:0]   fld_rd_pl [NUM_FIELDS];
    logic [DATA_W-1:0]   fld_q_pl  [NUM_FIELDS];
    logic [DATA_W-1:0]   reg_rd    [NUM_REGS+1];
    logic [DATA_W-1:0]   reg_q     [NUM_REGS];

    fbank_decode #(.ADDR_W(ADDR_W), .NREG(NUM_REGS)) u_dec (
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .reg_rd(reg_rd), .wr_stb(wr_stb), .rd_stb(rd_stb), .bus_rdata(bus_rdata)
    );

    fbank_irq #(.W(IRQ_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .evt(hw_evt), .rd_clr(rd_stb[NUM_REGS]), .stat(irq_stat)
    );

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
        localparam int RIX = int'(FIELDS[i].reg_idx);
        localparam int LSB = int'(FIELDS[i].lsb);
        localparam int W   = int'(FIELDS[i].width);
        if (FIELDS[i].acc == ACC_RO) begin : g_ro
            localparam int HB = ro_base(i);
            assign fld_rd_pl[i] = DATA_W'(hw_stat[HB +: W]) << LSB;
            assign fld_q_pl[i]  = '0;
        end else begin : g_st
            logic [W-1:0] q, rv;
            fbank_field #(
                .W(W), .ACC(FIELDS[i].acc), .RULE(FIELDS[i].rule),
                .REFF(FIELDS[i].reff), .RST(REG_RST[RIX][LSB +: W])
            ) u_fld (
                .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb[RIX]), .rd_stb(rd_stb[RIX]),
                .wdata(bus_wdata[LSB +: W]), .fld_q(q), .rd_val(rv)
            );
            assign fld_rd_pl[i] = DATA_W'(rv) << LSB;
            assign fld_q_pl[i]  = DATA_W'(q) << LSB;
        end
    end

    // Assemble register words from the placed field slices
    always_comb begin
        for (int r = 0; r < NUM_REGS; r++) begin
            reg_rd[r] = '0;
            reg_q[r]  = '0;
            for (int i = 0; i < NUM_FIELDS; i++) begin
                if (int'(FIELDS[i].reg_idx) == r) begin
                    reg_rd[r] = reg_rd[r] | fld_rd_pl[i];
                    reg_q[r]  = reg_q[r] | fld_q_pl[i];
                end
            end
        end
        reg_rd[NUM_REGS] = DATA_W'(irq_stat);
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_out
        assign fld_out[r*DATA_W +: DATA_W] = reg_q[r];
    end
endmodule

// File: rtl/fbank_chk.sv
// Checker for fbank_top: port-level properties of decode, mux and interrupt word.
// Assumes: the default field layout of fbank_pkg (write-only byte at word 2).
module fbank_chk import fbank_pkg::*; #(
    parameter int ADDR_W = 4,
    parameter int IRQ_W  = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_sel,
    input logic                       bus_wr,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [DATA_W-1:0]          bus_rdata,
    input logic [IRQ_W-1:0]           hw_evt,
    input logic [NUM_REGS*DATA_W-1:0] fld_out,
    input logic [IRQ_W-1:0]           irq_stat
);
    localparam logic [ADDR_W-1:0] IRQ_A = ADDR_W'(IRQ_OFF);
    localparam logic [ADDR_W-1:0] WO_A  = ADDR_W'(2);

    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> $stable(fld_out));
    assert_unmapped_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr > IRQ_A) |-> bus_rdata == '0);
    assert_unmapped_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr > IRQ_A) |=> $stable(fld_out));
    assert_wo_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == WO_A) |-> bus_rdata[7:0] == 8'h00);
    assert_evt_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_evt != '0) |=> ((irq_stat & $past(hw_evt)) == $past(hw_evt)));
    assert_flag_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr && bus_addr == IRQ_A) |=> ((irq_stat & $past(irq_stat)) == $past(irq_stat)));
    assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == IRQ_A) |=> irq_stat == $past(hw_evt));
    assert_irq_wr_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == IRQ_A) |=> irq_stat == ($past(irq_stat) | $past(hw_evt)));
endmodule

bind fbank_top fbank_chk #(.ADDR_W(ADDR_W), .IRQ_W(IRQ_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .hw_evt(hw_evt), .fld_out(fld_out), .irq_stat(irq_stat)
);

// File: tb/sim_fbank_top.sv
// Bench for fbank_top: directed corner cases, then seeded random traffic,
// all compared against a field-level model written from the requirements.
module sim_fbank_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [7:0]   hw_stat = 8'hC3;
    logic [7:0]   hw_evt = '0;
    logic [127:0] fld_out;
    logic [7:0]   irq_stat;
    int n_chk = 0, n_fail = 0;

    // model state, one variable per field
    logic [7:0] a, f, g, k, n, o, p, irq;
    logic [3:0] b, c, d, h, i4, j, l, m;
    bit f_done, g_done;

    always #10 clk = ~clk;   // 50 MHz

    fbank_top u0 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_stat(hw_stat), .hw_evt(hw_evt), .fld_out(fld_out), .irq_stat(irq_stat));

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void mdl_reset();
        a = 8'h5A; b = 4'hF; c = 0; d = 0;
        f = 8'h11; g = 8'h22; h = 4'hF; i4 = 0; j = 0; f_done = 0; g_done = 0;
        k = 8'h33; l = 4'h7; m = 0; n = 8'hA5; o = 0; p = 8'h0F; irq = 0;
    endfunction

    function automatic logic [31:0] exp_read(input logic [3:0] ad);
        case (ad)
            4'd0: return {hw_stat, 4'h0, d, c, b, a};
            4'd1: return {4'h0, j, i4, h, 8'h00, f};
            4'd2: return {o, n, m, l, 8'h00};
            4'd3: return {24'h0, p};
            4'd4: return {24'h0, irq};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [127:0] exp_fld();
        return {24'h0, p, o, n, m, l, k, 4'h0, j, i4, h, g, f, 12'h0, d, c, b, a};
    endfunction

    function automatic void mdl_write(input logic [3:0] ad, input logic [31:0] w);
        case (ad)
            4'd0: begin a = w[7:0]; b = b & ~w[11:8]; c = c | w[15:12]; d = d ^ w[19:16]; end
            4'd1: begin
                if (!f_done) begin f = w[7:0];  f_done = 1; end
                if (!g_done) begin g = w[15:8]; g_done = 1; end
                h = h & w[19:16]; i4 = i4 | ~w[23:20]; j = j ^ ~w[27:24];
            end
            4'd2: begin k = w[7:0]; l = 0; m = 4'hF; n = w[23:16]; o = w[31:24]; end
            4'd3: p = w[7:0];
            default: ;
        endcase
    endfunction

    function automatic void mdl_read(input logic [3:0] ad);
        case (ad)
            4'd2: begin n = 0; o = 8'hFF; end
            4'd3: p = ~p;
            4'd4: irq = 0;
            default: ;
        endcase
    endfunction

    // One bus cycle; starts and ends just after a falling edge
    task automatic step(input string tag, input bit sel, input bit wr,
                        input logic [3:0] ad, input logic [31:0] w, input logic [7:0] ev);
        bus_sel = sel; bus_wr = wr; bus_addr = ad; bus_wdata = w; hw_evt = ev;
        #5;
        if (sel && !wr) chk({tag, " rdata"}, 128'(bus_rdata), 128'(exp_read(ad)));
        @(posedge clk);
        if (sel && wr)  mdl_write(ad, w);
        if (sel && !wr) mdl_read(ad);
        irq = irq | ev;
        @(negedge clk);
        bus_sel = 0; hw_evt = 0;
        chk({tag, " fld_out"}, fld_out, exp_fld());
        chk({tag, " irq_stat"}, 128'(irq_stat), 128'(irq));
    endtask

    task automatic do_reset();
        bus_sel = 0; hw_evt = 0; rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        mdl_reset();
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        @(negedge clk);
        do_reset();
        // R1: reset image on outputs and read-back
        chk("R1 fld_out", fld_out, 128'h0000000F_00A50733_000F2211_00000F5A);
        chk("R1 irq_stat", 128'(irq_stat), 128'h0);
        step("R1", 1, 0, 4'd0, 0, 0);
        step("R1", 1, 0, 4'd1, 0, 0);
        step("R1", 1, 0, 4'd3, 0, 0);
        step("R1", 1, 0, 4'd4, 0, 0);
        // R2: unselected write and plain read change nothing
        step("R2", 0, 1, 4'd0, 32'hFFFF_FFFF, 0);
        step("R2", 1, 0, 4'd0, 32'hFFFF_FFFF, 0);
        // R3: unmapped addresses
        step("R3", 1, 0, 4'd7, 0, 0);
        step("R3", 1, 1, 4'd9, 32'hFFFF_FFFF, 0);
        step("R3", 1, 0, 4'd15, 0, 0);
        // R4: read-only byte follows hw_stat, ignores writes
        hw_stat = 8'h96;
        step("R4", 1, 1, 4'd0, 32'hFF00_0000, 0);
        step("R4", 1, 0, 4'd0, 0, 0);
        // R6: one-to-clear/set/toggle and plain byte
        step("R6", 1, 1, 4'd0, 32'h0005_5A3C, 0);
        step("R6", 1, 0, 4'd0, 0, 0);
        step("R6", 1, 1, 4'd0, 32'h000F_A0C1, 0);
        step("R6", 1, 0, 4'd0, 0, 0);
        // R7 and R9: zero-to rules, first write to once-only fields sticks
        step("R9", 1, 1, 4'd1, 32'h0A5A_C3E7, 0);
        step("R7", 1, 0, 4'd1, 0, 0);
        step("R9", 1, 1, 4'd1, 32'h0FFF_7E18, 0);
        step("R7", 1, 0, 4'd1, 0, 0);
        // R5 and R8: write-only byte and any-write rules
        step("R5", 1, 1, 4'd2, 32'h1234_56C9, 0);
        step("R8", 1, 0, 4'd2, 0, 0);
        // R10: side effects show on the following read
        step("R10", 1, 1, 4'd2, 32'h4477_0000, 0);
        step("R10", 1, 0, 4'd2, 0, 0);
        step("R10", 1, 0, 4'd2, 0, 0);
        step("R10", 1, 0, 4'd3, 0, 0);
        step("R10", 1, 0, 4'd3, 0, 0);
        // R11: events set, read clears, set wins on collision
        step("R11", 1, 0, 4'd0, 0, 8'h24);
        step("R11", 0, 0, 4'd0, 0, 8'h01);
        step("R11", 1, 0, 4'd4, 0, 8'h80);
        step("R11", 1, 0, 4'd4, 0, 0);
        step("R11", 1, 0, 4'd4, 0, 0);
        // R12: writes to the interrupt word do nothing
        step("R12", 0, 0, 4'd0, 0, 8'h0F);
        step("R12", 1, 1, 4'd4, 32'hFFFF_FFFF, 0);
        step("R12", 1, 1, 4'd4, 32'h0, 8'h10);
        // R9: reset re-arms once-only fields
        do_reset();
        step("R9", 1, 1, 4'd1, 32'h00FF_6699, 0);
        step("R9", 1, 0, 4'd1, 0, 0);
        // R13 plus all rules: random traffic, read data checked in-cycle
        for (int t = 0; t < 800; t++) begin
            bit sel_r, wr_r;
            logic [3:0] ad_r;
            logic [7:0] ev_r;
            sel_r = ($urandom % 4) != 0;
            wr_r  = $urandom % 2;
            ad_r  = 4'($urandom % 8);
            ev_r  = (($urandom % 3) == 0) ? 8'($urandom) : 8'h0;
            if (($urandom % 16) == 0) hw_stat = 8'($urandom);
            step("R13", sel_r, wr_r, ad_r, $urandom, ev_r);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule